// File: doc/BRIEF.md
# Pseudo-Static RAM Page Burst Reader

This engine sits on the host side of an asynchronous pseudo-static RAM and fetches one whole page per request. A request gives a word address and a page-size code. The engine selects the memory, holds the address for one full random-access time, and captures the first word. It then moves only the low address bits, one shorter page-access time per word, until every word of the page has been read. The low bits count upward from the starting word and wrap at the page boundary. The page-select bits above them never move. Each captured word leaves on a one-cycle strobe together with its address. The final word carries a last flag.

After the last word the memory is deselected for a fixed gap before the next request is taken. A request whose select window would be longer than the allowed continuous-select time is refused with a one-cycle reject pulse and never reaches the memory. The reserved size code is refused the same way. All timing is counted in clock cycles and is set by parameters. Writes, low-power modes and the power-up wait belong to the caller.

Top module: `psram_page_reader`

## Requirements
- R1: `req_len` selects the page size: 0 gives 4 words, 1 gives 8 words and 2 gives 16 words. An accepted request delivers exactly that many word strobes, and `word_last` is set on the final strobe only.
- R2: During a burst, every address bit above the page's varying bits (bits 1:0, 2:0 or 3:0 for sizes 4, 8 and 16) keeps its value. The varying bits start at the requested offset and count up by one per word, modulo the page size.
- R3: `mem_ce_n` falls and `mem_addr` takes the request address on the clock edge that accepts the request. The first word is captured exactly FIRST_CYC cycles later.
- R4: Each later word is captured exactly PAGE_CYC cycles after the word before it, and the address moves on the same edge as the previous capture.
- R5: `mem_we_n` and `mem_zz_n` stay high at all times. `mem_oe_n` is low exactly when `mem_ce_n` is low. `mem_be_n` is 2'b00 while selected and 2'b11 otherwise.
- R6: `mem_ce_n` rises on the edge that captures the last word and stays high for GAP_CYC cycles. `req_ready` stays low during that gap.
- R7: A request whose select window FIRST_CYC + (words-1)*PAGE_CYC exceeds MAX_SEL_CYC is refused. A window equal to the limit is accepted.
- R8: A refused request, whether oversized or using code 3, raises `req_reject` for one cycle, starting one cycle after it is presented. It leaves `mem_ce_n` high and produces no word strobe.
- R9: `word_data` equals the value on `mem_dq` at the capture edge. `word_addr` equals the address held on `mem_addr` at that edge. `word_valid` is high for one cycle per word.
- R10: After reset, `req_ready` is 1, `mem_ce_n` is 1, and `word_valid` and `req_reject` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | ADDR_W | Word address of the first word |
| req_len | input | 2 | Page-size code (0:4, 1:8, 2:16, 3:reserved) |
| req_reject | output | 1 | One-cycle pulse for a refused request |
| word_valid | output | 1 | Captured word strobe |
| word_data | output | DATA_W | Captured word |
| word_addr | output | ADDR_W | Address of the captured word |
| word_last | output | 1 | Final word of the page |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, held high |
| mem_zz_n | output | 1 | Memory sleep control, held high |
| mem_be_n | output | 2 | Byte enables, active low |
| mem_dq | input | DATA_W | Read data from memory |

## Verification
The assertions take two things for granted. First, `req_valid` is only sampled while `req_ready` is high. Second, the memory drives settled data whenever the engine captures. The bench keeps to the first by raising `req_valid` only after it sees `req_ready` high, and by holding it for exactly one edge. It keeps to the second with a memory model that returns a marker word instead of data unless the chip has been selected for FIRST_CYC cycles and the address has been steady for PAGE_CYC cycles. Any capture taken too early therefore shows up as a data mismatch. A second instance with a select limit one cycle tighter is used to exercise the refusal of a 16-word request.

// File: rtl/psram_rd_pkg.sv
package psram_rd_pkg;

    localparam int PG_BITS = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_PAGE  = 2'd2,
        ST_GAP   = 2'd3
    } rd_state_t;

    typedef struct packed {
        logic               ok;
        logic [PG_BITS-1:0] mask;
        logic [PG_BITS-1:0] last_idx;
    } rd_plan_t;

    function automatic int unsigned page_words(input logic [1:0] code);
        case (code)
            2'd0:    page_words = 4;
            2'd1:    page_words = 8;
            2'd2:    page_words = 16;
            default: page_words = 4;
        endcase
    endfunction

    function automatic int unsigned select_window(input int unsigned first,
                                                  input int unsigned page,
                                                  input int unsigned words);
        select_window = first + (words - 1) * page;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        max3 = (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/prd_req_decode.sv
module prd_req_decode
    import psram_rd_pkg::*;
#(
    parameter int unsigned FIRST_CYC   = 7,
    parameter int unsigned PAGE_CYC    = 4,
    parameter int unsigned MAX_SEL_CYC = 4000
) (
    input  logic [1:0] len_code,
    output rd_plan_t   plan
);
    int unsigned words;
    int unsigned window;

    always_comb begin
        words         = page_words(len_code);
        window        = select_window(FIRST_CYC, PAGE_CYC, words);
        plan.mask     = PG_BITS'(words - 1);
        plan.last_idx = PG_BITS'(words - 1);
        plan.ok       = (len_code != 2'd3) && (window <= MAX_SEL_CYC);
    end

endmodule

// File: rtl/prd_addr_wrap.sv
module prd_addr_wrap
    import psram_rd_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0]  cur,
    input  logic [PG_BITS-1:0] mask,
    output logic [ADDR_W-1:0]  nxt
);
    logic [PG_BITS-1:0] inc;

    assign inc = cur[PG_BITS-1:0] + PG_BITS'(1);

    genvar i;
    generate
        for (i = 0; i < PG_BITS; i++) begin : g_low
            assign nxt[i] = mask[i] ? inc[i] : cur[i];
        end
        if (ADDR_W > PG_BITS) begin : g_high
            assign nxt[ADDR_W-1:PG_BITS] = cur[ADDR_W-1:PG_BITS];
        end
    endgenerate

endmodule

// File: rtl/prd_timer.sv
module prd_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign expire = (cnt == '0);

endmodule

// File: rtl/prd_ctrl.sv
module prd_ctrl
    import psram_rd_pkg::*;
#(
    parameter int          ADDR_W      = 20,
    parameter int          DATA_W      = 16,
    parameter int unsigned FIRST_CYC   = 7,
    parameter int unsigned PAGE_CYC    = 4,
    parameter int unsigned GAP_CYC     = 2,
    parameter int unsigned MAX_SEL_CYC = 4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  rd_plan_t          plan,
    output logic              req_ready,
    output logic              req_reject,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data,
    output logic [ADDR_W-1:0] word_addr,
    output logic              word_last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PG_BITS-1:0] cur_mask,
    input  logic [ADDR_W-1:0] next_addr,
    output logic              mem_ce_n,
    input  logic [DATA_W-1:0] mem_dq
);
    localparam int unsigned MAXC = max3(FIRST_CYC, PAGE_CYC, GAP_CYC);
    localparam int TW = $clog2(MAXC + 1);
    localparam logic [TW-1:0] LD_FIRST = TW'(FIRST_CYC - 1);
    localparam logic [TW-1:0] LD_PAGE  = TW'(PAGE_CYC - 1);
    localparam logic [TW-1:0] LD_GAP   = TW'(GAP_CYC - 1);

    rd_state_t          state;
    logic [PG_BITS-1:0] left;
    logic               expire;
    logic               tm_load;
    logic [TW-1:0]      tm_val;
    logic               accept;
    logic               capture;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid && plan.ok;
    assign capture   = ((state == ST_FIRST) || (state == ST_PAGE)) && expire;

    always_comb begin
        tm_load = accept || capture;
        if (accept)
            tm_val = LD_FIRST;
        else if (left == '0)
            tm_val = LD_GAP;
        else
            tm_val = LD_PAGE;
    end

    prd_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tm_load),
        .load_val (tm_val),
        .expire   (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            left       <= '0;
            cur_mask   <= '0;
            mem_addr   <= '0;
            mem_ce_n   <= 1'b1;
            req_reject <= 1'b0;
            word_valid <= 1'b0;
            word_data  <= '0;
            word_addr  <= '0;
            word_last  <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            req_reject <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (plan.ok) begin
                            mem_addr <= req_addr;
                            cur_mask <= plan.mask;
                            left     <= plan.last_idx;
                            mem_ce_n <= 1'b0;
                            state    <= ST_FIRST;
                        end else begin
                            req_reject <= 1'b1;
                        end
                    end
                end
                ST_FIRST, ST_PAGE: begin
                    if (expire) begin
                        word_valid <= 1'b1;
                        word_data  <= mem_dq;
                        word_addr  <= mem_addr;
                        word_last  <= (left == '0);
                        if (left == '0) begin
                            mem_ce_n <= 1'b1;
                            state    <= ST_GAP;
                        end else begin
                            mem_addr <= next_addr;
                            left     <= left - PG_BITS'(1);
                            state    <= ST_PAGE;
                        end
                    end
                end
                ST_GAP: begin
                    if (expire)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // select-window watch for the limit check
    int unsigned sel_cnt;
    always_ff @(posedge clk) begin
        if (rst || mem_ce_n)
            sel_cnt <= 0;
        else
            sel_cnt <= sel_cnt + 1;
    end

    p_sel_limit_r7: assert property (@(posedge clk) disable iff (rst)
        sel_cnt <= MAX_SEL_CYC);

    p_upper_fixed_r2: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |->
        ((mem_addr & ~ADDR_W'(cur_mask)) == ($past(mem_addr) & ~ADDR_W'(cur_mask))));

    p_low_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n) && (mem_addr != $past(mem_addr))) |->
        ((mem_addr[PG_BITS-1:0] & cur_mask) ==
         (($past(mem_addr[PG_BITS-1:0]) + PG_BITS'(1)) & cur_mask)));

    p_last_closes_r6: assert property (@(posedge clk) disable iff (rst)
        (word_valid && word_last) |-> (mem_ce_n && !req_ready));

    p_word_needs_select_r9: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> $past(!mem_ce_n));

    p_reject_idle_r8: assert property (@(posedge clk) disable iff (rst)
        req_reject |-> (mem_ce_n && !word_valid));

endmodule

// File: rtl/psram_page_reader.sv
module psram_page_reader
    import psram_rd_pkg::*;
#(
    parameter int          ADDR_W      = 20,
    parameter int          DATA_W      = 16,
    parameter int unsigned FIRST_CYC   = 7,
    parameter int unsigned PAGE_CYC    = 4,
    parameter int unsigned GAP_CYC     = 2,
    parameter int unsigned MAX_SEL_CYC = 4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_len,
    output logic              req_reject,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data,
    output logic [ADDR_W-1:0] word_addr,
    output logic              word_last,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_zz_n,
    output logic [1:0]        mem_be_n,
    input  logic [DATA_W-1:0] mem_dq
);
    rd_plan_t           plan;
    logic [PG_BITS-1:0] cur_mask;
    logic [ADDR_W-1:0]  next_addr;

    prd_req_decode #(
        .FIRST_CYC   (FIRST_CYC),
        .PAGE_CYC    (PAGE_CYC),
        .MAX_SEL_CYC (MAX_SEL_CYC)
    ) u_decode (
        .len_code (req_len),
        .plan     (plan)
    );

    prd_addr_wrap #(.ADDR_W(ADDR_W)) u_wrap (
        .cur  (mem_addr),
        .mask (cur_mask),
        .nxt  (next_addr)
    );

    prd_ctrl #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .FIRST_CYC   (FIRST_CYC),
        .PAGE_CYC    (PAGE_CYC),
        .GAP_CYC     (GAP_CYC),
        .MAX_SEL_CYC (MAX_SEL_CYC)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .plan       (plan),
        .req_ready  (req_ready),
        .req_reject (req_reject),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_addr  (word_addr),
        .word_last  (word_last),
        .mem_addr   (mem_addr),
        .cur_mask   (cur_mask),
        .next_addr  (next_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_dq     (mem_dq)
    );

    assign mem_oe_n = mem_ce_n;
    assign mem_we_n = 1'b1;
    assign mem_zz_n = 1'b1;
    assign mem_be_n = {2{mem_ce_n}};

endmodule

// File: tb/psram_page_reader_bench.sv
module psram_page_reader_bench;
    localparam int FIRST = 7;
    localparam int PAGE  = 4;
    localparam int GAP   = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_len = '0;
    logic        req_ready, req_reject, word_valid, word_last;
    logic [15:0] word_data;
    logic [19:0] word_addr, mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_zz_n;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq = 16'hBAD0;

    logic        t_valid = 1'b0;
    logic [19:0] t_addr_in = '0;
    logic [1:0]  t_len = '0;
    logic        t_ready, t_reject, t_wv, t_wl, t_ce, t_oe, t_we, t_zz;
    logic [15:0] t_wd;
    logic [19:0] t_wa, t_maddr;
    logic [1:0]  t_be;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit chk_on = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    psram_page_reader #(.FIRST_CYC(FIRST), .PAGE_CYC(PAGE), .GAP_CYC(GAP),
                        .MAX_SEL_CYC(67)) u_psram_page_reader (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .req_reject(req_reject),
        .word_valid(word_valid), .word_data(word_data), .word_addr(word_addr),
        .word_last(word_last), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_zz_n(mem_zz_n),
        .mem_be_n(mem_be_n), .mem_dq(mem_dq));

    psram_page_reader #(.FIRST_CYC(FIRST), .PAGE_CYC(PAGE), .GAP_CYC(GAP),
                        .MAX_SEL_CYC(66)) u_tight_limit (
        .clk(clk), .rst(rst), .req_valid(t_valid), .req_ready(t_ready),
        .req_addr(t_addr_in), .req_len(t_len), .req_reject(t_reject),
        .word_valid(t_wv), .word_data(t_wd), .word_addr(t_wa),
        .word_last(t_wl), .mem_addr(t_maddr), .mem_ce_n(t_ce),
        .mem_oe_n(t_oe), .mem_we_n(t_we), .mem_zz_n(t_zz),
        .mem_be_n(t_be), .mem_dq(pat(t_maddr)));

    function automatic logic [15:0] pat(input logic [19:0] a);
        pat = a[15:0] ^ {4{a[19:16]}} ^ 16'h3C69;
    endfunction

    typedef struct {
        int          at;
        logic [19:0] a;
        logic [15:0] d;
        logic        last;
    } exp_t;
    exp_t exq[$];
    int   rejq[$];

    task automatic check(input bit ok, input string req, input string msg,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)",
                     req, msg, act, exp, cyc);
        end
    endtask

    // memory model: data is valid only once access timings are met
    int          ce_cnt = 0;
    int          a_cnt = 0;
    logic [19:0] last_a = '0;
    always @(negedge clk) begin
        if (mem_ce_n) begin
            ce_cnt = 0;
            a_cnt  = 0;
        end else begin
            ce_cnt++;
            if (ce_cnt == 1 || mem_addr != last_a) a_cnt = 1;
            else a_cnt++;
        end
        last_a = mem_addr;
        mem_dq = (ce_cnt >= FIRST && a_cnt >= PAGE) ? pat(mem_addr) : 16'hBAD0;
    end

    // per-cycle comparison against the expectation queues
    int  hi_run = 1000;
    bit  prev_ce = 1'b1;
    always @(negedge clk) begin
        if (chk_on) begin
            if (exq.size() > 0 && exq[0].at == cyc) begin
                check(word_valid === 1'b1, "R3/R4", "word strobe", word_valid, 1);
                check(word_addr === exq[0].a, "R2", "word address", word_addr, exq[0].a);
                check(word_data === exq[0].d, "R9", "word data", word_data, exq[0].d);
                check(word_last === exq[0].last, "R1", "last flag", word_last, exq[0].last);
                void'(exq.pop_front());
            end else begin
                check(word_valid === 1'b0, "R9", "no strobe expected", word_valid, 0);
            end
            if (rejq.size() > 0 && rejq[0] == cyc) begin
                check(req_reject === 1'b1, "R8", "reject pulse", req_reject, 1);
                check(mem_ce_n === 1'b1, "R8", "no select on reject", mem_ce_n, 1);
                void'(rejq.pop_front());
            end else begin
                check(req_reject === 1'b0, "R8", "no reject", req_reject, 0);
            end
            check(mem_we_n === 1'b1 && mem_zz_n === 1'b1, "R5", "we/zz high",
                  {mem_we_n, mem_zz_n}, 2'b11);
            check(mem_oe_n === mem_ce_n, "R5", "oe follows ce", mem_oe_n, mem_ce_n);
            check(mem_be_n === {2{mem_ce_n}}, "R5", "byte enables", mem_be_n, {2{mem_ce_n}});
            if (mem_ce_n) begin
                if (!prev_ce) hi_run = 0;
                hi_run++;
                if (hi_run < GAP)
                    check(req_ready === 1'b0, "R6", "ready during gap", req_ready, 0);
            end else if (prev_ce) begin
                check(hi_run >= GAP, "R6", "deselect gap", hi_run, GAP);
            end
            prev_ce = mem_ce_n;
        end
    end

    task automatic issue(input logic [19:0] a, input logic [1:0] code, input bit ok);
        int n;
        logic [19:0] m;
        while (req_ready !== 1'b1) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_len   = code;
        n = (code == 2'd0) ? 4 : (code == 2'd1) ? 8 : 16;
        m = 20'(n - 1);
        if (ok) begin
            for (int i = 0; i < n; i++) begin
                exp_t e;
                e.a    = (a & ~m) | ((a + 20'(i)) & m);
                e.d    = pat(e.a);
                e.at   = cyc + 1 + FIRST + i * PAGE;
                e.last = (i == n - 1);
                exq.push_back(e);
            end
        end else begin
            rejq.push_back(cyc + 1);
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1, "R10", "ready after reset", req_ready, 1);
        check(mem_ce_n === 1'b1, "R10", "ce after reset", mem_ce_n, 1);
        check(word_valid === 1'b0 && req_reject === 1'b0, "R10", "strobes after reset",
              {word_valid, req_reject}, 0);
        chk_on = 1;

        issue(20'h12340, 2'd0, 1);      // R1 4 words from offset 0
        issue(20'h12343, 2'd0, 1);      // R2 wrap from the last word
        issue(20'hABCD5, 2'd1, 1);      // R2 8 words from offset 5
        issue(20'h00008, 2'd1, 1);
        issue(20'hFFFF7, 2'd2, 1);      // R7 window 67 equals the limit
        issue(20'h5555F, 2'd3, 0);      // R8 reserved code
        issue(20'h55550, 2'd2, 1);      // R4 16 words from offset 0
        issue(20'h0000E, 2'd1, 1);
        while (exq.size() > 0) @(negedge clk);
        repeat (4) @(negedge clk);

        // tighter limit: a 16-word window of 67 exceeds 66 (R7)
        t_valid = 1'b1; t_addr_in = 20'h33330; t_len = 2'd2;
        @(negedge clk);
        t_valid = 1'b0;
        check(t_reject === 1'b1, "R7", "oversized request refused", t_reject, 1);
        check(t_ce === 1'b1, "R7", "oversized request not selected", t_ce, 1);
        @(negedge clk);
        check(t_reject === 1'b0 && t_ce === 1'b1, "R8", "reject one cycle",
              {t_reject, t_ce}, 2'b01);
        t_valid = 1'b1; t_len = 2'd1;
        @(negedge clk);
        t_valid = 1'b0;
        check(t_reject === 1'b0 && t_ce === 1'b0, "R7", "8-word window within limit",
              {t_reject, t_ce}, 2'b00);
        repeat (40) @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule